// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block keeps the coherence state of every line of a small private cache that shares a snooping bus with other caches. Each line is Modified, Shared or Invalid, and holds one data word. The processor side issues read and write requests with a valid/ready handshake. The bus side carries snooped read and read-exclusive requests from other caches. For each request the block picks the next line state and any bus action: a bus read, a bus read-exclusive, or a write-back of a dirty line.

The protocol has no upgrade message. A write to a Shared line issues a full read-exclusive, the same as a write miss. A snooped read of a Modified line forces a write-back and leaves the line Shared. Bus requests use a request/grant handshake: the block raises a request with its command and line index, and the arbiter grants it. In the grant cycle the arbiter supplies the fetched word. Write-backs caused by snoops are single-cycle pulses on a separate output group.

Lines are selected directly by a line index. Lines reset to Invalid, and data words are not initialised. At least two lines are required.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_ready`, `bus_req` and `snp_wb` are low with `bus_cmd` = 2'b00. A snoop to any line then gives no write-back, and a processor read to any line issues a bus read.
- R2: A processor read of a Modified or Shared line raises no bus request. `cpu_ready` is a one-cycle pulse in the cycle after the request is accepted, with the line's word on `cpu_rdata`. The line state does not change.
- R3: A processor write to a Modified line raises no bus request, stores `cpu_wdata` and leaves the line Modified.
- R4: A processor write to a Shared or Invalid line raises `bus_req` with `bus_cmd` = 2'b10 (read-exclusive). After the grant the line is Modified and holds the written word.
- R5: A processor read of an Invalid line raises `bus_req` with `bus_cmd` = 2'b01 (read). After the grant, `cpu_rdata` equals the `bus_rdata` of the grant cycle and the line is Shared.
- R6: A snooped read (`snp_excl` = 0) of a Modified line pulses `snp_wb` for one cycle, in the cycle after the snoop, with the line index and data. The line becomes Shared.
- R7: A snooped read-exclusive (`snp_excl` = 1) of a Modified line pulses `snp_wb` with the line index and data, and the line becomes Invalid.
- R8: A snooped read of a Shared line gives no write-back and the line stays Shared. A snooped read-exclusive of a Shared line gives no write-back and invalidates the line. A snoop of an Invalid line changes nothing.
- R9: When a snoop and a new processor request name the same line in the same cycle, the snoop is applied first. The processor request is accepted one cycle later and decided on the state the snoop left.
- R10: While `bus_req` is high without a grant, `bus_req`, `bus_cmd` and `bus_addr` stay stable and `cpu_ready` stays low.
- R11: A grant in a cycle where a snoop names the pending line is not taken. The request stays high, and the transfer completes on the next grant cycle without such a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | IDX_W | Line index of the processor request |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_ready` |
| snp_valid | input | 1 | Snooped bus request valid for one cycle |
| snp_excl | input | 1 | 1 = read-exclusive, 0 = read |
| snp_addr | input | IDX_W | Line index of the snooped request |
| snp_wb | output | 1 | Write-back pulse for a dirty snooped line |
| snp_wb_addr | output | IDX_W | Line index being written back |
| snp_wb_data | output | DATA_W | Word being written back |
| bus_req | output | 1 | Bus request, held until granted |
| bus_cmd | output | 2 | 2'b01 read, 2'b10 read-exclusive, 2'b00 none |
| bus_addr | output | IDX_W | Line index of the bus request |
| bus_gnt | input | 1 | Bus grant, sampled while `bus_req` is high |
| bus_rdata | input | DATA_W | Fetched word, valid with the grant |

## Verification
The hardest situations to reach are two collisions on one line: a snoop and a processor request arriving together, and a grant arriving while a snoop hits the pending line. The stimulus drives both sides from one task at the same falling edge. In the first case it makes a line Modified, then presents a processor read together with a read-exclusive snoop to that line. It expects a write-back first, then a bus read. In the second case it holds back the grant, then raises the grant and a same-line snoop together. It expects the request to survive that cycle and to complete one cycle later.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'b00,
    BC_READ  = 2'b01,
    BC_READX = 2'b10
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CF_IDLE = 2'b00,
    CF_WAIT = 2'b01,
    CF_RESP = 2'b10
  } cf_e;

endpackage

// File: rtl/msi_policy.sv
module msi_policy
  import msi_pkg::*;
(
  input  line_st_e cpu_st,
  input  logic     cpu_wr,
  input  line_st_e snp_st,
  input  logic     snp_excl,
  output logic     cpu_bus,
  output bus_cmd_e cpu_cmd,
  output line_st_e cpu_next,
  output logic     snp_flush,
  output line_st_e snp_next
);

  // processor side transition
  always_comb begin
    cpu_bus  = 1'b0;
    cpu_cmd  = BC_NONE;
    cpu_next = cpu_st;
    unique case (cpu_st)
      LN_MOD: begin
        cpu_next = LN_MOD;
      end
      LN_SHR: begin
        if (cpu_wr) begin
          cpu_bus  = 1'b1;
          cpu_cmd  = BC_READX;
          cpu_next = LN_MOD;
        end
      end
      default: begin
        cpu_bus  = 1'b1;
        cpu_cmd  = cpu_wr ? BC_READX : BC_READ;
        cpu_next = cpu_wr ? LN_MOD : LN_SHR;
      end
    endcase
  end

  // snoop side transition
  always_comb begin
    snp_flush = 1'b0;
    snp_next  = snp_st;
    unique case (snp_st)
      LN_MOD: begin
        snp_flush = 1'b1;
        snp_next  = snp_excl ? LN_INV : LN_SHR;
      end
      LN_SHR: begin
        snp_next = snp_excl ? LN_INV : LN_SHR;
      end
      default: begin
        snp_next = LN_INV;
      end
    endcase
  end

endmodule

// File: rtl/msi_line_bank.sv
module msi_line_bank
  import msi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  line_st_e         wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_e         wb_st,
  input  logic [IDX_W-1:0] ra_idx,
  output line_st_e         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output line_st_e         rb_st
);

  localparam int ST_W = 2;

  logic [LINES*ST_W-1:0] st_flat;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e st_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_r <= LN_INV;
      end else if (wa_en && wa_idx == IDX_W'(i)) begin
        st_r <= wa_st;
      end else if (wb_en && wb_idx == IDX_W'(i)) begin
        st_r <= wb_st;
      end
    end
    assign st_flat[i*ST_W +: ST_W] = st_r;
  end

  assign ra_st = line_st_e'(st_flat[ra_idx*ST_W +: ST_W]);
  assign rb_st = line_st_e'(st_flat[rb_idx*ST_W +: ST_W]);

  // R9
  port_collision_chk: assert property (@(posedge clk) disable iff (rst)
    !(wa_en && wb_en && wa_idx == wb_idx));

endmodule

// File: rtl/msi_data_ram.sv
module msi_data_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [IDX_W-1:0]  snp_addr,
  output logic              snp_wb,
  output logic [IDX_W-1:0]  snp_wb_addr,
  output logic [DATA_W-1:0] snp_wb_data,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [IDX_W-1:0]  bus_addr,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata
);

  line_st_e cpu_st, snp_st, cpu_next, snp_next, pend_next_q;
  logic     cpu_bus, snp_flush;
  bus_cmd_e cpu_cmd;
  cf_e      cf_q;

  logic              pend_wr_q;
  logic [DATA_W-1:0] pend_wd_q;
  logic [DATA_W-1:0] cpu_word, snp_word;

  logic snp_same_cpu, snp_same_bus, accept, hit_go, miss_go, fill;
  logic              st_we;
  logic [IDX_W-1:0]  st_idx;
  line_st_e          st_val;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_addr;
  logic [DATA_W-1:0] ram_wdata;

  msi_policy u_policy (
    .cpu_st    (cpu_st),
    .cpu_wr    (cpu_write),
    .snp_st    (snp_st),
    .snp_excl  (snp_excl),
    .cpu_bus   (cpu_bus),
    .cpu_cmd   (cpu_cmd),
    .cpu_next  (cpu_next),
    .snp_flush (snp_flush),
    .snp_next  (snp_next)
  );

  // snoop hazards against a new request and against the pending one
  assign snp_same_cpu = snp_valid && (snp_addr == cpu_addr);
  assign snp_same_bus = snp_valid && (snp_addr == bus_addr);
  assign accept  = (cf_q == CF_IDLE) && cpu_valid && !snp_same_cpu;
  assign hit_go  = accept && !cpu_bus;
  assign miss_go = accept && cpu_bus;
  assign fill    = (cf_q == CF_WAIT) && bus_gnt && !snp_same_bus;

  assign st_we  = hit_go || fill;
  assign st_idx = fill ? bus_addr : cpu_addr;
  assign st_val = fill ? pend_next_q : cpu_next;

  msi_line_bank #(.LINES(LINES), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wa_en  (snp_valid),
    .wa_idx (snp_addr),
    .wa_st  (snp_next),
    .wb_en  (st_we),
    .wb_idx (st_idx),
    .wb_st  (st_val),
    .ra_idx (cpu_addr),
    .ra_st  (cpu_st),
    .rb_idx (snp_addr),
    .rb_st  (snp_st)
  );

  assign ram_we    = (hit_go && cpu_write) || fill;
  assign ram_addr  = fill ? bus_addr : cpu_addr;
  assign ram_wdata = fill ? (pend_wr_q ? pend_wd_q : bus_rdata) : cpu_wdata;

  msi_data_ram #(.DEPTH(LINES), .WIDTH(DATA_W), .AW(IDX_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_addr),
    .wdata   (ram_wdata),
    .ra_addr (cpu_addr),
    .ra_data (cpu_word),
    .rb_addr (snp_addr),
    .rb_data (snp_word)
  );

  // processor request sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      cf_q        <= CF_IDLE;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
      bus_req     <= 1'b0;
      bus_cmd     <= BC_NONE;
      bus_addr    <= '0;
      pend_wr_q   <= 1'b0;
      pend_wd_q   <= '0;
      pend_next_q <= LN_INV;
    end else begin
      unique case (cf_q)
        CF_IDLE: begin
          if (hit_go) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= cpu_write ? cpu_wdata : cpu_word;
            cf_q      <= CF_RESP;
          end else if (miss_go) begin
            bus_req     <= 1'b1;
            bus_cmd     <= cpu_cmd;
            bus_addr    <= cpu_addr;
            pend_wr_q   <= cpu_write;
            pend_wd_q   <= cpu_wdata;
            pend_next_q <= cpu_next;
            cf_q        <= CF_WAIT;
          end
        end
        CF_WAIT: begin
          if (fill) begin
            bus_req   <= 1'b0;
            bus_cmd   <= BC_NONE;
            cpu_ready <= 1'b1;
            cpu_rdata <= pend_wr_q ? pend_wd_q : bus_rdata;
            cf_q      <= CF_RESP;
          end
        end
        default: begin
          cpu_ready <= 1'b0;
          cf_q      <= CF_IDLE;
        end
      endcase
    end
  end

  // snoop write-back output
  always_ff @(posedge clk) begin
    if (rst) begin
      snp_wb      <= 1'b0;
      snp_wb_addr <= '0;
      snp_wb_data <= '0;
    end else begin
      snp_wb      <= snp_valid && snp_flush;
      snp_wb_addr <= snp_addr;
      snp_wb_data <= snp_word;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !cpu_ready);

  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R6
  wb_cause_chk: assert property (@(posedge clk) disable iff (rst)
    snp_wb |-> $past(snp_valid));

  // R4
  req_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_cmd == 2'b01 || bus_cmd == 2'b10));

  // R11
  gnt_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && snp_valid && snp_addr == bus_addr) |=> bus_req);

endmodule

// File: tb/sim_msi_line_ctrl.sv
module sim_msi_line_ctrl;

  localparam int LINES  = 8;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(LINES);
  localparam int NV     = 21;

  // vector: [19:18] op (0 rd,1 wr,2 snoop rd,3 snoop rdx), [17:15] line,
  // [14:13] expected bus_cmd (cpu ops) / bit13 expected write-back (snoops),
  // [12:9] requirement number, [7:0] data byte
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 3'd0, 2'd1, 4'd5,  1'b0, 8'h10},  // R5 read miss
    {2'd0, 3'd0, 2'd0, 4'd2,  1'b0, 8'h00},  // R2 read hit S
    {2'd1, 3'd0, 2'd2, 4'd4,  1'b0, 8'h21},  // R4 write S
    {2'd1, 3'd0, 2'd0, 4'd3,  1'b0, 8'h22},  // R3 write M
    {2'd0, 3'd0, 2'd0, 4'd2,  1'b0, 8'h00},  // R2 read hit M
    {2'd2, 3'd0, 2'd1, 4'd6,  1'b0, 8'h00},  // R6 snoop rd M
    {2'd0, 3'd0, 2'd0, 4'd6,  1'b0, 8'h00},  // R6 now S
    {2'd1, 3'd0, 2'd2, 4'd6,  1'b0, 8'h33},  // R6 not M
    {2'd3, 3'd0, 2'd1, 4'd7,  1'b0, 8'h00},  // R7 snoop rdx M
    {2'd0, 3'd0, 2'd1, 4'd7,  1'b0, 8'h44},  // R7 now I
    {2'd2, 3'd0, 2'd0, 4'd8,  1'b0, 8'h00},  // R8 snoop rd S
    {2'd0, 3'd0, 2'd0, 4'd8,  1'b0, 8'h00},  // R8 stays S
    {2'd3, 3'd0, 2'd0, 4'd8,  1'b0, 8'h00},  // R8 snoop rdx S
    {2'd0, 3'd0, 2'd1, 4'd8,  1'b0, 8'h55},  // R8 now I
    {2'd1, 3'd1, 2'd2, 4'd4,  1'b0, 8'h66},  // R4 write I
    {2'd2, 3'd2, 2'd0, 4'd8,  1'b0, 8'h00},  // R8 snoop I
    {2'd3, 3'd1, 2'd1, 4'd7,  1'b0, 8'h00},  // R7 snoop rdx M
    {2'd1, 3'd1, 2'd2, 4'd7,  1'b0, 8'h77},  // R7 write I
    {2'd1, 3'd7, 2'd2, 4'd4,  1'b0, 8'h88},  // R4 top line
    {2'd2, 3'd7, 2'd1, 4'd6,  1'b0, 8'h00},  // R6 top line
    {2'd0, 3'd7, 2'd0, 4'd2,  1'b0, 8'h00}   // R2 top line S
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [IDX_W-1:0]  cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic              snp_valid = 1'b0, snp_excl = 1'b0;
  logic [IDX_W-1:0]  snp_addr = '0;
  logic              snp_wb;
  logic [IDX_W-1:0]  snp_wb_addr;
  logic [DATA_W-1:0] snp_wb_data;
  logic              bus_req;
  logic [1:0]        bus_cmd;
  logic [IDX_W-1:0]  bus_addr;
  logic              bus_gnt = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  logic [DATA_W-1:0] mdl [LINES];

  always #5 clk = ~clk;

  msi_line_ctrl #(.LINES(LINES), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .snp_wb(snp_wb), .snp_wb_addr(snp_wb_addr), .snp_wb_data(snp_wb_data),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_access(input logic wr, input logic [IDX_W-1:0] a,
                            input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] fd,
                            input int gdly, output logic saw, output logic [1:0] cmd,
                            output logic [DATA_W-1:0] rd, output bit hold_ok);
    int  waited = 0;
    bit  done = 0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
    saw = 1'b0; cmd = 2'b00; rd = '0; hold_ok = 1;
    while (!done) begin
      @(negedge clk);
      if (cpu_ready) begin
        rd = cpu_rdata; done = 1; cpu_valid = 1'b0; bus_gnt = 1'b0;
      end else if (bus_req) begin
        if (!saw) begin
          saw = 1'b1; cmd = bus_cmd;
        end else if (bus_cmd != cmd || bus_addr != a) begin
          hold_ok = 0;
        end
        if (waited == gdly) begin
          bus_gnt = 1'b1; bus_rdata = fd;
        end
        waited++;
      end
    end
  endtask

  task automatic snoop(input logic ex, input logic [IDX_W-1:0] a, output logic wb,
                       output logic [IDX_W-1:0] wa, output logic [DATA_W-1:0] wd);
    @(negedge clk);
    snp_valid = 1'b1; snp_excl = ex; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    wb = snp_wb; wa = snp_wb_addr; wd = snp_wb_data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic              saw, wb;
    logic [1:0]        cmd;
    logic [DATA_W-1:0] rd, wdv, exp_rd;
    logic [IDX_W-1:0]  wa;
    bit                hold_ok;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset outputs
    chk(!cpu_ready && !bus_req && !snp_wb && bus_cmd == 2'b00, "R1 outputs after reset",
        {cpu_ready, bus_req, snp_wb, bus_cmd}, '0);
    // R1 all lines invalid: snoops give no write-back
    for (int i = 0; i < LINES; i++) begin
      snoop(1'b0, IDX_W'(i), wb, wa, wdv);
      chk(!wb, "R1 snoop after reset gives no write-back", {31'd0, wb}, '0);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0]       op;
      logic [IDX_W-1:0] a;
      logic [1:0]       ec;
      logic [3:0]       rq;
      logic [DATA_W-1:0] dv;
      op = VEC[v][19:18]; a = VEC[v][17:15]; ec = VEC[v][14:13];
      rq = VEC[v][12:9];  dv = {24'hC0FFEE, VEC[v][7:0]};
      if (op[1] == 1'b0) begin
        cpu_access(op[0], a, dv, dv, 1, saw, cmd, rd, hold_ok);
        exp_rd = (ec != 2'b00 || op[0]) ? dv : mdl[a];
        if (op[0] || ec != 2'b00) mdl[a] = dv;
        total++;
        if ((saw ? cmd : 2'b00) != ec || rd != exp_rd || !hold_ok) begin
          bad++;
          $display("FAIL R%0d vector %0d act cmd=%0d rd=%h exp cmd=%0d rd=%h",
                   rq, v, saw ? cmd : 2'b00, rd, ec, exp_rd);
        end
      end else begin
        snoop(op[0], a, wb, wa, wdv);
        total++;
        if (wb != ec[0] || (wb && (wa != a || wdv != mdl[a]))) begin
          bad++;
          $display("FAIL R%0d vector %0d act wb=%0d data=%h exp wb=%0d data=%h",
                   rq, v, wb, wdv, ec[0], mdl[a]);
        end
      end
    end

    // R10 long grant delay: request held, ready low
    cpu_access(1'b1, 3'd3, 32'h0000_3A3A, 32'hDEAD_0003, 6, saw, cmd, rd, hold_ok);
    mdl[3] = 32'h0000_3A3A;
    chk(saw && cmd == 2'b10 && hold_ok, "R10 request held through grant delay",
        {29'd0, hold_ok, cmd}, {29'd0, 1'b1, 2'b10});
    chk(rd == 32'h0000_3A3A, "R4 write data returned", rd, 32'h0000_3A3A);

    // R9 same line snoop rdx and processor read together on a Modified line
    cpu_access(1'b1, 3'd4, 32'h4444_0004, 32'h0, 0, saw, cmd, rd, hold_ok);
    mdl[4] = 32'h4444_0004;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 3'd4;
    snp_valid = 1'b1; snp_excl = 1'b1; snp_addr = 3'd4;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(snp_wb && snp_wb_data == mdl[4] && !bus_req && !cpu_ready,
        "R9 snoop served first with write-back", snp_wb_data, mdl[4]);
    @(negedge clk);
    chk(bus_req && bus_cmd == 2'b01, "R9 processor read sees Invalid line",
        {30'd0, bus_cmd}, 32'd1);
    bus_gnt = 1'b1; bus_rdata = 32'hF00D_0004;
    @(negedge clk);
    bus_gnt = 1'b0; cpu_valid = 1'b0;
    chk(cpu_ready && cpu_rdata == 32'hF00D_0004, "R5 fill data after R9 case",
        cpu_rdata, 32'hF00D_0004);
    mdl[4] = 32'hF00D_0004;

    // R11 grant during a same-line snoop is not taken
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 3'd5;
    @(negedge clk);
    chk(bus_req && bus_cmd == 2'b01, "R1 read of untouched line issues bus read",
        {30'd0, bus_cmd}, 32'd1);
    bus_gnt = 1'b1; bus_rdata = 32'hAAAA_0005;
    snp_valid = 1'b1; snp_excl = 1'b0; snp_addr = 3'd5;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(bus_req && !cpu_ready, "R11 grant ignored during same-line snoop",
        {31'd0, bus_req}, 32'd1);
    bus_rdata = 32'hBBBB_0005;
    @(negedge clk);
    bus_gnt = 1'b0; cpu_valid = 1'b0;
    chk(cpu_ready && cpu_rdata == 32'hBBBB_0005, "R11 transfer completes on next grant",
        cpu_rdata, 32'hBBBB_0005);
    mdl[5] = 32'hBBBB_0005;

    // R2 read hit after R11 fill, line stays Shared
    cpu_access(1'b0, 3'd5, 32'h0, 32'h0, 0, saw, cmd, rd, hold_ok);
    chk(!saw && rd == mdl[5], "R2 read hit on filled line", rd, mdl[5]);

    // R3 write to Modified line 3 then snoop returns new word
    cpu_access(1'b1, 3'd3, 32'h3333_BEEF, 32'h0, 0, saw, cmd, rd, hold_ok);
    chk(!saw, "R3 write to Modified line without bus", {31'd0, saw}, 32'd0);
    snoop(1'b0, 3'd3, wb, wa, wdv);
    chk(wb && wa == 3'd3 && wdv == 32'h3333_BEEF, "R6 write-back carries stored word",
        wdv, 32'h3333_BEEF);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule